// File: doc/BRIEF.md
# Index Register Address Generator

This block keeps a small file of byte-wide general registers and treats adjacent pairs of them as 16-bit index registers. On each memory request it forms a data memory byte address from the selected index register and the requested addressing mode. Where the mode asks for it, it also steps that index register up or down by one. The address is produced even when no memory write follows, so a jump unit can use it as a target.

Software-visible bytes are loaded through a single byte write port and read back through a combinational byte read port. The index registers are simply views of those bytes. Six mode codes are decoded:
- plain use;
- post-decrement;
- post-increment;
- pre-increment;
- last-index-plus-immediate;
- selected-index-plus-accumulator.

Top module: `idx_agen`

## Requirements
- R1: After reset, `ea` is 0, `ea_vld` is 0 and every byte read through `rd_byte`/`rd_data` is 0.
- R2: A write with `wr_en` high stores `wr_data` into byte `wr_byte` at the next edge, and that byte reads back through `rd_byte`. Index register k is the 16-bit value {byte 2k+1, byte 2k}, with the odd byte as the upper half.
- R3: Mode code 0 (plain) yields the selected index register as the address and leaves it unchanged.
- R4: Mode code 2 (post-increment) and code 1 (post-decrement) yield the old value of the selected index register as the address. They then write back that value plus one or minus one, respectively.
- R5: Mode code 3 (pre-increment) writes back the selected index register plus one and yields that new value as the address.
- R6: Mode code 4 (immediate-relative) yields the last index register (bytes 7:6 by default) plus the zero-extended `req_imm`, whatever `req_sel` holds. No register changes.
- R7: Mode code 5 (accumulator-relative) yields the selected index register plus the zero-extended `req_acc`. No register changes.
- R8: All sums and steps wrap modulo 2^16: FFFF+1 gives 0000 and 0000-1 gives FFFF.
- R9: `ea_vld` is high exactly one cycle after a request with `req_vld` high and a legal mode (0 to 5). `ea` takes that request's address in the same cycle and otherwise holds its last value. Codes 6 and 7 are reserved; they raise no `ea_vld` and change no register.
- R10: If an index update and a byte write hit the same pair in one cycle, the update wins for both bytes. A byte write to another pair, or alongside a mode that does not update, still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Address request strobe |
| req_sel | input | 2 | Index register select |
| req_mode | input | 3 | Addressing mode code |
| req_imm | input | 8 | Unsigned immediate offset |
| req_acc | input | 8 | Unsigned accumulator offset |
| wr_en | input | 1 | Byte register write enable |
| wr_byte | input | 3 | Byte register number to write |
| wr_data | input | 8 | Byte write data |
| rd_byte | input | 3 | Byte register number to read |
| rd_data | output | 8 | Byte read data (combinational) |
| ea | output | 16 | Registered effective address |
| ea_vld | output | 1 | Registered address valid |

## Verification
Directed cases put index registers at FFFF and 0000 before stepping them, which separates a correct wrap from a carry into the wrong byte or a sign-extended offset. An immediate-relative request is issued with a non-last select, which shows whether the select is wrongly honoured. Collision cases combine an update with a write to the same pair, to a different pair and alongside a non-updating mode, which isolates the priority rule. A long random mix of all eight mode codes, selects, offsets and concurrent byte writes is compared against a bench model after every cycle, including a full byte readback, so any stray write or missed step shows up.

// File: rtl/idx_agen_pkg.sv
`timescale 1ns/1ps
package idx_agen_pkg;

  typedef enum logic [2:0] {
    AM_HOLD    = 3'd0,
    AM_POSTDEC = 3'd1,
    AM_POSTINC = 3'd2,
    AM_PREINC  = 3'd3,
    AM_IMMREL  = 3'd4,
    AM_ACCREL  = 3'd5
  } am_e;

  function automatic logic am_legal(input logic [2:0] m);
    return m <= 3'd5;
  endfunction

  function automatic logic am_updates(input logic [2:0] m);
    return (m == AM_POSTDEC) || (m == AM_POSTINC) || (m == AM_PREINC);
  endfunction

endpackage

// File: rtl/idx_pair.sv
`timescale 1ns/1ps
module idx_pair #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              upd_en,
  input  logic [2*BYTE_W-1:0] upd_val,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q
);

  // Index update takes precedence over a byte write into the same pair.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (upd_en) begin
      lo_q <= upd_val[BYTE_W-1:0];
      hi_q <= upd_val[2*BYTE_W-1:BYTE_W];
    end else begin
      if (lo_we) lo_q <= wr_data;
      if (hi_we) hi_q <= wr_data;
    end
  end

endmodule

// File: rtl/idx_addr_calc.sv
`timescale 1ns/1ps
module idx_addr_calc
  import idx_agen_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_IDX = 4
) (
  input  logic [2:0]                    mode,
  input  logic [$clog2(NUM_IDX)-1:0]    sel,
  input  logic [BYTE_W-1:0]             imm,
  input  logic [BYTE_W-1:0]             acc,
  input  logic [NUM_IDX*2*BYTE_W-1:0]   idx_all,
  output logic [2*BYTE_W-1:0]           addr,
  output logic [2*BYTE_W-1:0]           next_val,
  output logic                          legal,
  output logic                          writeback
);

  localparam int ADDR_W = 2 * BYTE_W;
  localparam int LAST   = NUM_IDX - 1;

  function automatic logic [ADDR_W-1:0] add_unsigned(
      input logic [ADDR_W-1:0] base, input logic [BYTE_W-1:0] off);
    return base + ADDR_W'(off);
  endfunction

  function automatic logic [ADDR_W-1:0] step_one(
      input logic [ADDR_W-1:0] base, input logic down);
    return down ? base - ADDR_W'(1) : base + ADDR_W'(1);
  endfunction

  logic [ADDR_W-1:0] sel_val;
  logic [ADDR_W-1:0] last_val;

  assign sel_val  = idx_all[sel*ADDR_W +: ADDR_W];
  assign last_val = idx_all[LAST*ADDR_W +: ADDR_W];
  assign legal     = am_legal(mode);
  assign writeback = am_updates(mode);

  always_comb begin
    addr     = sel_val;
    next_val = sel_val;
    case (mode)
      AM_POSTDEC: next_val = step_one(sel_val, 1'b1);
      AM_POSTINC: next_val = step_one(sel_val, 1'b0);
      AM_PREINC: begin
        next_val = step_one(sel_val, 1'b0);
        addr     = next_val;
      end
      AM_IMMREL:  addr = add_unsigned(last_val, imm);
      AM_ACCREL:  addr = add_unsigned(sel_val, acc);
      default: ;
    endcase
  end

endmodule

// File: rtl/idx_agen.sv
`timescale 1ns/1ps
module idx_agen
  import idx_agen_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_IDX = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_vld,
  input  logic [$clog2(NUM_IDX)-1:0]      req_sel,
  input  logic [2:0]                      req_mode,
  input  logic [BYTE_W-1:0]               req_imm,
  input  logic [BYTE_W-1:0]               req_acc,
  input  logic                            wr_en,
  input  logic [$clog2(2*NUM_IDX)-1:0]    wr_byte,
  input  logic [BYTE_W-1:0]               wr_data,
  input  logic [$clog2(2*NUM_IDX)-1:0]    rd_byte,
  output logic [BYTE_W-1:0]               rd_data,
  output logic [2*BYTE_W-1:0]             ea,
  output logic                            ea_vld
);

  localparam int ADDR_W = 2 * BYTE_W;
  localparam int SEL_W  = $clog2(NUM_IDX);
  localparam int BSEL_W = $clog2(2 * NUM_IDX);

  // Byte b sits at bits [b*BYTE_W +: BYTE_W]; pair k is therefore {byte 2k+1, byte 2k}.
  logic [NUM_IDX*ADDR_W-1:0] idx_all;
  logic [ADDR_W-1:0]         calc_addr;
  logic [ADDR_W-1:0]         calc_next;
  logic                      calc_legal;
  logic                      calc_wb;
  logic                      req_fire;
  logic [NUM_IDX-1:0]        upd_hit;

  idx_addr_calc #(.BYTE_W(BYTE_W), .NUM_IDX(NUM_IDX)) i_calc (
    .mode      (req_mode),
    .sel       (req_sel),
    .imm       (req_imm),
    .acc       (req_acc),
    .idx_all   (idx_all),
    .addr      (calc_addr),
    .next_val  (calc_next),
    .legal     (calc_legal),
    .writeback (calc_wb)
  );

  assign req_fire = req_vld & calc_legal;

  for (genvar k = 0; k < NUM_IDX; k++) begin : g_pair
    logic lo_we_k;
    logic hi_we_k;
    logic [BYTE_W-1:0] lo_k;
    logic [BYTE_W-1:0] hi_k;

    assign upd_hit[k] = req_fire & calc_wb & (req_sel == SEL_W'(k));
    assign lo_we_k    = wr_en & (wr_byte == BSEL_W'(2*k));
    assign hi_we_k    = wr_en & (wr_byte == BSEL_W'(2*k+1));

    idx_pair #(.BYTE_W(BYTE_W)) i_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_we   (lo_we_k),
      .hi_we   (hi_we_k),
      .wr_data (wr_data),
      .upd_en  (upd_hit[k]),
      .upd_val (calc_next),
      .lo_q    (lo_k),
      .hi_q    (hi_k)
    );

    assign idx_all[k*ADDR_W +: ADDR_W] = {hi_k, lo_k};
  end

  assign rd_data = idx_all[rd_byte*BYTE_W +: BYTE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ea     <= '0;
      ea_vld <= 1'b0;
    end else begin
      ea_vld <= req_fire;
      if (req_fire) ea <= calc_addr;
    end
  end

endmodule

// File: rtl/idx_agen_chk.sv
`timescale 1ns/1ps
module idx_agen_chk
  import idx_agen_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int NUM_IDX = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          req_vld,
  input logic [$clog2(NUM_IDX)-1:0]    req_sel,
  input logic [2:0]                    req_mode,
  input logic                          wr_en,
  input logic [2*BYTE_W-1:0]           ea,
  input logic                          ea_vld,
  input logic [NUM_IDX*2*BYTE_W-1:0]   idx_all,
  input logic [NUM_IDX-1:0]            upd_hit
);

  localparam int ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] sel_val;
  assign sel_val = idx_all[req_sel*ADDR_W +: ADDR_W];

  // R9: a legal request is followed by a valid strobe
  a_r9_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && am_legal(req_mode)) |=> ea_vld);

  // R9: no strobe without a legal request
  a_r9_no_spurious_vld: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_vld && am_legal(req_mode)) |=> !ea_vld);

  // R4: post-increment hands out the value before the step
  a_r4_postinc_old_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode == AM_POSTINC) |=> (ea == $past(sel_val)));

  // R5: pre-increment address equals the register content afterwards
  a_r5_preinc_matches_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode == AM_PREINC) |=>
      (ea == idx_all[$past(req_sel)*ADDR_W +: ADDR_W]));

  // R3: plain mode without a byte write leaves every index register alone
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_mode == AM_HOLD && !wr_en) |=> $stable(idx_all));

  // R7: relative modes without a byte write leave every index register alone
  a_r7_rel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_mode == AM_ACCREL || req_mode == AM_IMMREL) && !wr_en)
      |=> $stable(idx_all));

  // R10: at most one pair is updated per request
  a_r10_single_update: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_hit));

endmodule

bind idx_agen idx_agen_chk #(.BYTE_W(BYTE_W), .NUM_IDX(NUM_IDX)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_vld  (req_vld),
  .req_sel  (req_sel),
  .req_mode (req_mode),
  .wr_en    (wr_en),
  .ea       (ea),
  .ea_vld   (ea_vld),
  .idx_all  (idx_all),
  .upd_hit  (upd_hit)
);

// File: tb/test_idx_agen.sv
`timescale 1ns/1ps
module test_idx_agen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_vld = 1'b0;
  logic [1:0] req_sel = '0;
  logic [2:0] req_mode = '0;
  logic [7:0] req_imm = '0;
  logic [7:0] req_acc = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_byte = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_byte = '0;
  logic [7:0] rd_data;
  logic [15:0] ea;
  logic       ea_vld;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  int mdl[8];
  int ea_exp = 0;
  int vld_exp = 0;

  always #2 clk = ~clk;

  idx_agen i_idx_agen (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_sel(req_sel),
    .req_mode(req_mode), .req_imm(req_imm), .req_acc(req_acc),
    .wr_en(wr_en), .wr_byte(wr_byte), .wr_data(wr_data),
    .rd_byte(rd_byte), .rd_data(rd_data), .ea(ea), .ea_vld(ea_vld)
  );

  function automatic int pair_of(int k);
    return mdl[2*k+1] * 256 + mdl[2*k];
  endfunction

  function automatic int wrap16(int v);
    return ((v % 65536) + 65536) % 65536;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_bytes(string tag);
    for (int b = 0; b < 8; b++) begin
      rd_byte = 3'(b);
      #0.1;
      chk(tag, int'(rd_data), mdl[b]);
    end
  endtask

  // One request cycle with an optional concurrent byte write.
  task automatic op(bit v, int sel, int mode, int imm, int acc,
                    bit we, int wb, int wd, string tag);
    int base;
    int nxt;
    bit upd;
    req_vld = v; req_sel = 2'(sel); req_mode = 3'(mode);
    req_imm = 8'(imm); req_acc = 8'(acc);
    wr_en = we; wr_byte = 3'(wb); wr_data = 8'(wd);
    upd = 0; nxt = 0;
    vld_exp = (v && mode <= 5) ? 1 : 0;
    if (vld_exp == 1) begin
      base = (mode == 4) ? pair_of(3) : pair_of(sel);
      case (mode)
        1: begin upd = 1; nxt = wrap16(base - 1); ea_exp = base; end
        2: begin upd = 1; nxt = wrap16(base + 1); ea_exp = base; end
        3: begin upd = 1; nxt = wrap16(base + 1); ea_exp = nxt; end
        4: ea_exp = wrap16(base + imm);
        5: ea_exp = wrap16(base + acc);
        default: ea_exp = base;
      endcase
    end
    if (we) mdl[wb] = wd;
    if (upd) begin
      mdl[2*sel]   = nxt % 256;
      mdl[2*sel+1] = nxt / 256;
    end
    @(posedge clk);
    @(negedge clk);
    req_vld = 1'b0; wr_en = 1'b0;
    chk({tag, " vld"}, int'(ea_vld), vld_exp);
    chk({tag, " ea"}, int'(ea), ea_exp);
    check_bytes({tag, " regs"});
  endtask

  task automatic load_pair(int k, int val);
    op(0, 0, 0, 0, 0, 1, 2*k,   val % 256, "R2 load lo");
    op(0, 0, 0, 0, 0, 1, 2*k+1, val / 256, "R2 load hi");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 8; b++) mdl[b] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ea", int'(ea), 0);
    chk("R1 ea_vld", int'(ea_vld), 0);
    check_bytes("R1 regs");

    // R2 byte mapping: pair 1 = {byte3, byte2}
    load_pair(1, 16'h12AB);
    op(1, 1, 0, 0, 0, 0, 0, 0, "R2 R3 plain pair1");
    // R3 plain leaves register unchanged (checked by readback)
    op(1, 1, 0, 0, 0, 0, 0, 0, "R3 plain again");

    // R4 R8 post-increment wrap
    load_pair(0, 16'hFFFF);
    op(1, 0, 2, 0, 0, 0, 0, 0, "R4 R8 postinc FFFF");
    op(1, 0, 0, 0, 0, 0, 0, 0, "R4 R8 after postinc");
    // R4 R8 post-decrement wrap
    op(1, 0, 1, 0, 0, 0, 0, 0, "R4 R8 postdec 0000");
    // R5 R8 pre-increment wrap
    op(1, 0, 3, 0, 0, 0, 0, 0, "R5 R8 preinc FFFF");

    // R6 immediate-relative ignores select, zero-extends, wraps
    load_pair(3, 16'hFFF0);
    op(1, 1, 4, 8'h20, 8'hFF, 0, 0, 0, "R6 R8 immrel sel1");
    op(1, 3, 4, 8'h80, 0, 0, 0, 0, "R6 immrel high imm");
    // R7 accumulator-relative unsigned
    op(1, 1, 5, 8'h00, 8'h85, 0, 0, 0, "R7 accrel");

    // R9 reserved codes, idle cycle holds ea
    op(1, 2, 6, 0, 0, 0, 0, 0, "R9 reserved 6");
    op(1, 0, 7, 0, 0, 0, 0, 0, "R9 reserved 7");
    op(0, 0, 2, 0, 0, 0, 0, 0, "R9 idle no req");

    // R10 collision: update beats write to same pair
    load_pair(2, 16'h4000);
    op(1, 2, 2, 0, 0, 1, 4, 8'h77, "R10 upd beats lo write");
    op(1, 2, 1, 0, 0, 1, 5, 8'h99, "R10 upd beats hi write");
    op(1, 2, 3, 0, 0, 1, 0, 8'h5A, "R10 write other pair");
    op(1, 2, 0, 0, 0, 1, 4, 8'h3C, "R10 write with plain");
    op(1, 2, 5, 0, 8'h10, 1, 5, 8'hC3, "R10 write with accrel");

    // Random mix of all behaviours
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2500; i++) begin
      int md = int'($urandom % 8);
      int sl = int'($urandom % 4);
      bit we = $urandom % 2 == 0;
      int wb = int'($urandom % 8);
      int wd = ($urandom % 4 == 0) ? 8'hFF : int'($urandom % 256);
      op($urandom % 8 != 0, sl, md, int'($urandom % 256), int'($urandom % 256),
         we, wb, wd, "R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule